// File: doc/BRIEF.md
# Lowest-Priority Interrupt Delivery Arbiter

This block decides which one of a set of processor agents takes an incoming interrupt message under lowest-priority delivery. Each agent presents three values: an 8-bit task priority, the highest vector it has pending, and the highest vector it has in service. The arbiter forms each agent's effective priority from these three values. It then keeps only the agents that both match the message's destination and can accept the vector. From those it grants the interrupt to the one with the lowest effective priority.

The message carries a vector, a destination mode and a 32-bit destination field. Three destination modes are supported:

- A broadcast mode, in which every agent is a candidate.
- A flat logical mode, in which 8-bit IDs are compared with a bit mask.
- A cluster mode, in which a 16-bit cluster number must match and the agent's member bit must be selected.

A request is accepted every cycle. Its result appears one cycle later as a one-hot grant and a delivered flag. If no agent qualifies, the flag stays low.

Top module: `lpd_arbiter`

## Requirements
- R1: An agent's effective priority is the largest of its task priority, its pending vector with bits [3:0] cleared, and its in-service vector with bits [3:0] cleared.
- R2: An agent can accept a vector only when vector bits [7:4] are strictly greater than bits [7:4] of its effective priority. As a result, an agent with task priority 0xFF accepts nothing, and an agent never accepts a vector in its own effective class.
- R3: When no agent is both a destination match and able to accept, `delivered_o` is 0 and `grant_o` is all zero.
- R4: `req_mode_i` is encoded as follows: 0 is broadcast (all agents are candidates), 1 is flat logical, 2 is cluster, and 3 selects no agent.
- R5: In flat mode, an agent matches when bits [7:0] of its logical ID and bits [7:0] of `req_dest_i` share at least one set bit.
- R6: In cluster mode, an agent matches when bits [31:16] of its logical ID equal `req_dest_i[31:16]` and `req_dest_i[15:0]` has at least one bit in common with the agent's ID bits [15:0].
- R7: Among the eligible agents, the winner has the lowest full 8-bit effective priority. Ties go to the lowest agent index, so unchanged inputs always produce the same winner.
- R8: Task priorities below 0x20 block no vector in the range 0x20 to 0xFF, but they still take part in choosing the winner.
- R9: The result of a request sampled at one rising edge is shown at the next edge: `grant_valid_o` is high and `grant_o`/`delivered_o` carry the result. A new request is accepted every cycle. After a cycle with no request, all outputs are zero.
- R10: `grant_o` is always zero or one-hot, and `delivered_o` is high exactly when `grant_o` is non-zero.
- R11: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Interrupt message present this cycle |
| req_vector_i | input | 8 | Interrupt vector |
| req_mode_i | input | 2 | Destination mode (R4 encoding) |
| req_dest_i | input | 32 | Destination field |
| agent_tpr_i | input | 8*N_AGENTS | Task priority of each agent; agent i at [8i+7:8i] |
| agent_irr_i | input | 8*N_AGENTS | Highest pending vector of each agent (0 when none) |
| agent_isr_i | input | 8*N_AGENTS | Highest in-service vector of each agent (0 when none) |
| agent_ldr_i | input | 32*N_AGENTS | Logical ID of each agent; agent i at [32i+31:32i] |
| grant_valid_o | output | 1 | Result of the previous cycle's request is valid |
| grant_o | output | N_AGENTS | One-hot winner |
| delivered_o | output | 1 | Some agent took the interrupt |

## Verification
The bench targets several corner cases:

- Equal-class vectors. A design that compares with "at least" instead of "strictly greater" would deliver to agents whose task priority is 0xFF, or to agents whose own class equals the vector's.
- Pending and in-service raises. A design that forgets to clear the low nibble, or that ignores one of the two sources, would leave the winner unchanged where it should have moved.
- Tied priorities. A design that breaks ties towards the highest index, or that is unstable, would name a different agent on repeated identical requests.
- Cluster mode with a matching member mask but a wrong cluster number. A design that skips the cluster compare would grant that request.

Task priorities below 0x20 are also exercised, together with back-to-back requests.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int PRIO_W    = 8;
  localparam int CLS_W     = 4;
  localparam int ID_W      = 32;
  localparam int FLAT_W    = 8;
  localparam int CLUSTER_W = 16;

  typedef enum logic [1:0] {
    DM_BCAST   = 2'd0,
    DM_FLAT    = 2'd1,
    DM_CLUSTER = 2'd2,
    DM_NONE    = 2'd3
  } dest_mode_e;
endpackage

// File: rtl/lpd_prio_calc.sv
module lpd_prio_calc
  import lpd_pkg::*;
(
  input  logic [PRIO_W-1:0] tpr_i,
  input  logic [PRIO_W-1:0] irr_i,
  input  logic [PRIO_W-1:0] isr_i,
  input  logic [PRIO_W-1:0] vec_i,
  output logic [PRIO_W-1:0] eff_o,
  output logic              accept_o
);
  localparam logic [PRIO_W-1:0] ClsMask = {{CLS_W{1'b1}}, {(PRIO_W-CLS_W){1'b0}}};

  logic [PRIO_W-1:0] irr_cls, isr_cls, hi;

  always_comb begin
    irr_cls = irr_i & ClsMask;
    isr_cls = isr_i & ClsMask;
    hi      = (irr_cls > isr_cls) ? irr_cls : isr_cls;
    eff_o   = (tpr_i > hi) ? tpr_i : hi;
    // strict: equal class is blocked, so TPR 0xFF admits nothing
    accept_o = (vec_i & ClsMask) > (eff_o & ClsMask);
  end
endmodule

// File: rtl/lpd_dest_match.sv
module lpd_dest_match
  import lpd_pkg::*;
(
  input  dest_mode_e        mode_i,
  input  logic [ID_W-1:0]   ldr_i,
  input  logic [ID_W-1:0]   dest_i,
  output logic              hit_o
);
  always_comb begin
    unique case (mode_i)
      DM_BCAST:   hit_o = 1'b1;
      DM_FLAT:    hit_o = |(ldr_i[FLAT_W-1:0] & dest_i[FLAT_W-1:0]);
      DM_CLUSTER: hit_o = (ldr_i[ID_W-1:CLUSTER_W] == dest_i[ID_W-1:CLUSTER_W]) &&
                          (|(ldr_i[CLUSTER_W-1:0] & dest_i[CLUSTER_W-1:0]));
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpd_min_select.sv
module lpd_min_select #(
  parameter int N_AGENTS = 8,
  parameter int PRIO_W   = 8
) (
  input  logic [N_AGENTS-1:0]        elig_i,
  input  logic [N_AGENTS*PRIO_W-1:0] prio_i,
  output logic [N_AGENTS-1:0]        sel_o,
  output logic                       any_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    sel_o = '0;
    any_o = 1'b0;
    best  = '1;
    // strict less-than keeps the lowest index on a tie
    for (int i = 0; i < N_AGENTS; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        best     = prio_i[i*PRIO_W +: PRIO_W];
        sel_o    = '0;
        sel_o[i] = 1'b1;
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpd_arbiter.sv
module lpd_arbiter
  import lpd_pkg::*;
#(
  parameter int N_AGENTS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [PRIO_W-1:0]          req_vector_i,
  input  logic [1:0]                 req_mode_i,
  input  logic [ID_W-1:0]            req_dest_i,
  input  logic [N_AGENTS*PRIO_W-1:0] agent_tpr_i,
  input  logic [N_AGENTS*PRIO_W-1:0] agent_irr_i,
  input  logic [N_AGENTS*PRIO_W-1:0] agent_isr_i,
  input  logic [N_AGENTS*ID_W-1:0]   agent_ldr_i,
  output logic                       grant_valid_o,
  output logic [N_AGENTS-1:0]        grant_o,
  output logic                       delivered_o
);
  dest_mode_e                 mode;
  logic [N_AGENTS*PRIO_W-1:0] eff;
  logic [N_AGENTS-1:0]        accept, hit, elig, sel;
  logic                       any;

  assign mode = dest_mode_e'(req_mode_i);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    lpd_prio_calc u_prio (
      .tpr_i   (agent_tpr_i[g*PRIO_W +: PRIO_W]),
      .irr_i   (agent_irr_i[g*PRIO_W +: PRIO_W]),
      .isr_i   (agent_isr_i[g*PRIO_W +: PRIO_W]),
      .vec_i   (req_vector_i),
      .eff_o   (eff[g*PRIO_W +: PRIO_W]),
      .accept_o(accept[g])
    );
    lpd_dest_match u_dest (
      .mode_i(mode),
      .ldr_i (agent_ldr_i[g*ID_W +: ID_W]),
      .dest_i(req_dest_i),
      .hit_o (hit[g])
    );
  end

  assign elig = accept & hit;

  lpd_min_select #(.N_AGENTS(N_AGENTS), .PRIO_W(PRIO_W)) u_sel (
    .elig_i(elig),
    .prio_i(eff),
    .sel_o (sel),
    .any_o (any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_o       <= '0;
      delivered_o   <= 1'b0;
    end else begin
      grant_valid_o <= req_valid_i;
      grant_o       <= req_valid_i ? sel : '0;
      delivered_o   <= req_valid_i && any;
    end
  end
endmodule

// File: rtl/lpd_arbiter_chk.sv
module lpd_arbiter_chk #(
  parameter int N_AGENTS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [N_AGENTS*8-1:0] agent_tpr_i,
  input logic                  grant_valid_o,
  input logic [N_AGENTS-1:0]   grant_o,
  input logic                  delivered_o
);
  logic all_ff;
  always_comb begin
    all_ff = 1'b1;
    for (int i = 0; i < N_AGENTS; i++)
      if (agent_tpr_i[i*8 +: 8] != 8'hFF) all_ff = 1'b0;
  end

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r10_delivered_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delivered_o == (grant_o != '0));
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_valid_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!grant_valid_o && grant_o == '0 && !delivered_o));
  a_r2_all_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && all_ff) |=> !delivered_o);
endmodule

bind lpd_arbiter lpd_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .agent_tpr_i  (agent_tpr_i),
  .grant_valid_o(grant_valid_o),
  .grant_o      (grant_o),
  .delivered_o  (delivered_o)
);

// File: tb/sim_lpd_arbiter.sv
`timescale 1ns/1ps
module sim_lpd_arbiter;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [7:0]   req_vector_i = '0;
  logic [1:0]   req_mode_i = '0;
  logic [31:0]  req_dest_i = '0;
  logic [N*8-1:0]  agent_tpr_i, agent_irr_i, agent_isr_i;
  logic [N*32-1:0] agent_ldr_i;
  logic         grant_valid_o;
  logic [N-1:0] grant_o;
  logic         delivered_o;

  logic [7:0]  tpr [N];
  logic [7:0]  irr [N];
  logic [7:0]  isr [N];
  logic [31:0] ldr [N];

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk_i = ~clk_i;

  always_comb
    for (int i = 0; i < N; i++) begin
      agent_tpr_i[i*8 +: 8]   = tpr[i];
      agent_irr_i[i*8 +: 8]   = irr[i];
      agent_isr_i[i*8 +: 8]   = isr[i];
      agent_ldr_i[i*32 +: 32] = ldr[i];
    end

  lpd_arbiter #(.N_AGENTS(N)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [7:0] v, input logic [1:0] m, input logic [31:0] d);
    logic [N-1:0] g = '0;
    logic [7:0] best = 8'hFF;
    bit found = 0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] e = tpr[i];
      bit ok, hit;
      if ({irr[i][7:4], 4'h0} > e) e = {irr[i][7:4], 4'h0};
      if ({isr[i][7:4], 4'h0} > e) e = {isr[i][7:4], 4'h0};
      ok = v[7:4] > e[7:4];
      case (m)
        2'd0: hit = 1;
        2'd1: hit = (ldr[i][7:0] & d[7:0]) != 0;
        2'd2: hit = ldr[i][31:16] == d[31:16] && (ldr[i][15:0] & d[15:0]) != 0;
        default: hit = 0;
      endcase
      if (ok && hit && (!found || e < best)) begin
        best = e; g = '0; g[i] = 1'b1; found = 1;
      end
    end
    return g;
  endfunction

  // drive one request, check the result one edge later
  task automatic run(input logic [7:0] v, input logic [1:0] m, input logic [31:0] d,
                     input logic [N-1:0] exp, input string tag);
    req_valid_i = 1; req_vector_i = v; req_mode_i = m; req_dest_i = d;
    @(posedge clk_i); #1;
    chk(grant_valid_o === 1'b1, {tag, " valid"}, 32'(grant_valid_o), 1);
    chk(grant_o === exp, {tag, " grant"}, 32'(grant_o), 32'(exp));
    chk(delivered_o === (exp != 0), {tag, " delivered"}, 32'(delivered_o), 32'(exp != 0));
  endtask

  task automatic idle();
    req_valid_i = 0;
    @(posedge clk_i); #1;
  endtask

  task automatic clear_agents(input logic [7:0] t);
    for (int i = 0; i < N; i++) begin
      tpr[i] = t; irr[i] = 0; isr[i] = 0; ldr[i] = 32'(1 << i);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(grant_valid_o === 0 && grant_o === '0 && delivered_o === 0, "R11 reset",
        {grant_valid_o, delivered_o, 22'(0), grant_o}, 0);
  endtask

  task automatic t_stable_winner();
    clear_agents(8'h10);
    for (int k = 0; k < 3; k++) run(8'h41, 2'd0, 0, 8'h01, "R7 idle same winner");
  endtask

  task automatic t_pending_inservice();
    clear_agents(8'h10);
    irr[0] = 8'h35;
    run(8'h41, 2'd0, 0, 8'h02, "R1 pending raises agent0");
    isr[1] = 8'h52;
    run(8'h41, 2'd0, 0, 8'h04, "R1 R2 in-service blocks agent1");
  endtask

  task automatic t_low_tpr();
    clear_agents(8'h1F);
    tpr[5] = 8'h03;
    run(8'h20, 2'd0, 0, 8'h20, "R8 low tpr selects agent5");
  endtask

  task automatic t_blocked();
    clear_agents(8'hFF);
    run(8'hFF, 2'd0, 0, 8'h00, "R2 R3 tpr ff none");
    clear_agents(8'h40);
    run(8'h4F, 2'd0, 0, 8'h00, "R2 equal class none");
    tpr[3] = 8'h3F;
    run(8'h4F, 2'd0, 0, 8'h08, "R2 lower class agent3");
  endtask

  task automatic t_flat();
    clear_agents(8'h00);
    run(8'h60, 2'd1, 32'h30, 8'h10, "R5 flat tie agent4");
    tpr[4] = 8'h08;
    run(8'h60, 2'd1, 32'h30, 8'h20, "R5 flat agent5");
    run(8'h60, 2'd1, 32'hFFFF_FF00, 8'h00, "R5 flat no overlap");
  endtask

  task automatic t_cluster();
    clear_agents(8'h00);
    for (int i = 0; i < N; i++) ldr[i] = {(i < 4) ? 16'h0001 : 16'h0002, 16'(1 << (i % 4))};
    tpr[1] = 8'h05;
    run(8'h80, 2'd2, 32'h0001_0003, 8'h01, "R6 cluster agent0");
    tpr[0] = 8'h09;
    run(8'h80, 2'd2, 32'h0001_0003, 8'h02, "R6 cluster agent1");
    run(8'h80, 2'd2, 32'h0002_0002, 8'h20, "R6 cluster2 agent5");
    run(8'h80, 2'd2, 32'h0003_FFFF, 8'h00, "R6 wrong cluster");
    run(8'h80, 2'd3, 32'hFFFF_FFFF, 8'h00, "R4 mode3 none");
  endtask

  task automatic t_back_to_back();
    clear_agents(8'h00);
    tpr[0] = 8'h30;
    run(8'h90, 2'd0, 0, 8'h02, "R9 b2b first");
    run(8'h30, 2'd0, 0, 8'h02, "R9 b2b second");
    tpr[1] = 8'h50;
    run(8'h90, 2'd1, 32'h03, 8'h01, "R9 b2b third");
    idle();
    chk(grant_valid_o === 0 && grant_o === '0 && delivered_o === 0, "R9 idle outputs",
        {grant_valid_o, delivered_o, 22'(0), grant_o}, 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      logic [7:0] v;
      logic [1:0] m;
      logic [31:0] d;
      for (int i = 0; i < N; i++) begin
        tpr[i] = 8'($urandom_range(0, 255) >> ($urandom_range(0, 3)));
        irr[i] = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
        isr[i] = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
        ldr[i] = {16'($urandom_range(0, 2)), 16'($urandom)};
      end
      v = 8'($urandom_range(32, 255));
      m = 2'($urandom);
      d = {16'($urandom_range(0, 2)), 16'($urandom)};
      run(v, m, d, model(v, m, d), "R1 R2 R4 R7 random");
    end
  endtask

  initial begin
    clear_agents(8'h00);
    t_reset();
    #20 rst_ni = 1;
    @(negedge clk_i);
    t_stable_winner();
    t_pending_inservice();
    t_low_tpr();
    t_blocked();
    t_flat();
    t_cluster();
    t_back_to_back();
    t_random();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule